// File: doc/BRIEF.md
# Activity-Rearmed System Watchdog Timer

This block is a system watchdog built around a 16-bit down-counter. Software programs it through four byte-wide registers: a control register for activity-source enables, a forced expiry and a sticky expiry flag, a configuration register for the time unit, reset routing and an interrupt-line selection, and two bytes holding the timeout value. The counter decrements on a one-cycle time-base pulse supplied from outside the block. In minute units, an internal divide-by-60 prescaler stretches that pulse.

Besides a register write, activity on the platform can re-arm the count. Four sources can each be enabled on their own: a consumer-IR interrupt, a mouse interrupt, a keyboard interrupt and a game-port read. When the count runs out, the block sets the expiry flag and stops counting. It also drives a fixed-length pulse on a keyboard-controller reset output, on a power-good drop output, or on both, as routed. A timeout value of zero keeps the timer idle.

Top module: `wdog_timer`

## Requirements
- R1: After reset every register reads zero, both reset outputs and `expired` are low, and time-base pulses cause no expiry.
- R2: Registers sit at `ADDR_BASE`+0 (control), +1 (configuration), +2 (timeout low byte) and +3 (timeout high byte). Control bits are: 0 IR enable, 1 mouse enable, 2 keyboard enable, 3 game-port enable, 4 force (reads 0), 5 expiry flag; bits 7:6 read 0. Configuration bits are: 0 seconds unit when set (minutes when clear), 1 route to keyboard-controller reset, 2 route to power-good drop, 7:4 interrupt line shown on `irq_line_sel`; bit 3 reads 0. Timeout bytes read back as written.
- R3: A write to either timeout byte loads the counter with the full 16-bit value and restarts it. A value of zero leaves the timer stopped.
- R4: In seconds units, expiry happens on the N-th time-base pulse after a load of value N.
- R5: In minutes units, expiry happens on the 60·N-th pulse after a load. Every reload clears the prescaler.
- R6: A pulse on an enabled activity input reloads the counter from the programmed value. A pulse on a disabled input has no effect.
- R7: On expiry the expiry flag is set and counting stops. Further time-base pulses cause no new expiry until a reload.
- R8: Each routed reset output goes high in the cycle after expiry for exactly `PULSE_LEN` cycles. An unrouted output stays low.
- R9: Writing 1 to the force bit causes an expiry at that clock edge.
- R10: Writing 1 to the expiry flag bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle wins.
- R11: A reload in the same cycle as the final time-base pulse wins, and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| sec_tick | input | 1 | One-cycle time-base pulse, one per second |
| evt_ir | input | 1 | Consumer-IR interrupt activity pulse |
| evt_mouse | input | 1 | Mouse interrupt activity pulse |
| evt_kbd | input | 1 | Keyboard interrupt activity pulse |
| evt_game_rd | input | 1 | Game-port read activity pulse |
| kbc_rst | output | 1 | Keyboard-controller reset pulse |
| pwrgd_drop | output | 1 | Power-good deassertion pulse |
| irq_line_sel | output | 4 | Selected interrupt line |
| expired | output | 1 | Sticky expiry flag |

## Verification
The assertions check four things on every cycle: a reset pulse never runs longer than `PULSE_LEN` after the expiry that started it, a pulse never rises unless the expiry flag is set, every expiry sets the flag, and a force write always produces an expiry. The bench's scenarios are the only way to show the rest. That covers the exact pulse count needed to expire in each unit, the clearing of the prescaler on a reload, which activity sources are honoured, the 16-bit reach of the value, and the ordering when a reload and a final pulse coincide.

// File: rtl/wdog_pkg.sv
// Package: shared widths and register bit positions for the watchdog.
// Assumes byte-wide registers and a 16-bit timeout value.
package wdog_pkg;
    localparam int REG_W = 8;
    localparam int VAL_W = 2 * REG_W;
    localparam int N_EVT = 4;
    localparam int N_RST = 2;
    localparam int IRQ_W = 4;

    // control register bit positions
    localparam int C_EN_IR    = 0;
    localparam int C_EN_MOUSE = 1;
    localparam int C_EN_KBD   = 2;
    localparam int C_EN_GAME  = 3;
    localparam int C_FORCE    = 4;
    localparam int C_ZERO     = 5;

    // configuration register bit positions
    localparam int G_UNIT_SEC = 0;
    localparam int G_RT_KBC   = 1;
    localparam int G_RT_PWR   = 2;
    localparam int G_IRQ_LO   = 4;

    // reset output indices
    localparam int RST_KBC = 0;
    localparam int RST_PWR = 1;

    typedef logic [REG_W-1:0] reg_t;
    typedef logic [VAL_W-1:0] val_t;
endpackage

// File: rtl/wdog_regs.sv
// Register file: decodes writes, holds control/config/timeout bytes,
// produces load and force strobes and the read mux.
// Assumes one write per cycle; reads are combinational.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter logic [7:0] ADDR_BASE = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  reg_t             wdata,
    output reg_t             rdata,
    input  logic             expire_i,
    output logic [N_EVT-1:0] evt_en_o,
    output logic             unit_sec_o,
    output logic [N_RST-1:0] route_o,
    output logic [IRQ_W-1:0] irq_sel_o,
    output val_t             tv_o,
    output logic             load_o,
    output val_t             load_val_o,
    output logic             force_o,
    output logic             zero_o
);
    localparam logic [7:0] A_CTRL = ADDR_BASE;
    localparam logic [7:0] A_CFG  = ADDR_BASE + 8'd1;
    localparam logic [7:0] A_LO   = ADDR_BASE + 8'd2;
    localparam logic [7:0] A_HI   = ADDR_BASE + 8'd3;

    logic             hit_ctrl, hit_cfg, hit_lo, hit_hi;
    logic [N_EVT-1:0] evt_en_q;
    logic             unit_sec_q;
    logic [N_RST-1:0] route_q;
    logic [IRQ_W-1:0] irq_q;
    reg_t             lo_q, hi_q;
    logic             zero_q;

    // Address decode of the write strobe.
    always_comb begin
        hit_ctrl = wr_en && (addr == A_CTRL);
        hit_cfg  = wr_en && (addr == A_CFG);
        hit_lo   = wr_en && (addr == A_LO);
        hit_hi   = wr_en && (addr == A_HI);
    end

    // Register storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_en_q   <= '0;
            unit_sec_q <= 1'b0;
            route_q    <= '0;
            irq_q      <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
        end else begin
            if (hit_ctrl) evt_en_q <= wdata[N_EVT-1:0];
            if (hit_cfg) begin
                unit_sec_q        <= wdata[G_UNIT_SEC];
                route_q[RST_KBC]  <= wdata[G_RT_KBC];
                route_q[RST_PWR]  <= wdata[G_RT_PWR];
                irq_q             <= wdata[G_IRQ_LO +: IRQ_W];
            end
            if (hit_lo) lo_q <= wdata;
            if (hit_hi) hi_q <= wdata;
        end
    end

    // Sticky expiry flag: set by expiry, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                           zero_q <= 1'b0;
        else if (expire_i)                    zero_q <= 1'b1;
        else if (hit_ctrl && wdata[C_ZERO])   zero_q <= 1'b0;
    end

    // Strobes and the value merged with a write in flight.
    always_comb begin
        load_o     = hit_lo || hit_hi;
        load_val_o = {hit_hi ? wdata : hi_q, hit_lo ? wdata : lo_q};
        force_o    = hit_ctrl && wdata[C_FORCE];
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[N_EVT-1:0] = evt_en_q;
                rdata[C_ZERO]    = zero_q;
            end
            A_CFG: begin
                rdata[G_UNIT_SEC]          = unit_sec_q;
                rdata[G_RT_KBC]            = route_q[RST_KBC];
                rdata[G_RT_PWR]            = route_q[RST_PWR];
                rdata[G_IRQ_LO +: IRQ_W]   = irq_q;
            end
            A_LO:    rdata = lo_q;
            A_HI:    rdata = hi_q;
            default: rdata = '0;
        endcase
    end

    assign evt_en_o   = evt_en_q;
    assign unit_sec_o = unit_sec_q;
    assign route_o    = route_q;
    assign irq_sel_o  = irq_q;
    assign tv_o       = {hi_q, lo_q};
    assign zero_o     = zero_q;
endmodule

// File: rtl/wdog_prescale.sv
// Prescaler: passes the time-base pulse straight through in seconds
// mode, or emits one pulse per DIV input pulses in minutes mode.
// Assumes tick_i is a single-cycle pulse; clear_i restarts the phase.
module wdog_prescale #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    input  logic bypass_i,
    output logic unit_tick_o
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Unit pulse on the last phase, or on every pulse when bypassed.
    assign unit_tick_o = tick_i && (bypass_i || (phase_q == LAST));

    // Phase counter, cleared on reload.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)       phase_q <= '0;
        else if (tick_i && !bypass_i) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/wdog_count.sv
// Down-counter: loads on a write or an activity reload, decrements per
// unit pulse and flags expiry on reaching zero or on a force.
// Priority: force, then reload, then decrement.
module wdog_count
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  val_t load_val_i,
    input  logic reload_i,
    input  val_t tv_i,
    input  logic force_i,
    input  logic unit_tick_i,
    output logic restart_o,
    output logic expire_o
);
    val_t cnt_q;
    logic run_q;
    val_t next_val;

    // Reload source selection and expiry decision.
    always_comb begin
        restart_o = load_i || reload_i;
        next_val  = load_i ? load_val_i : tv_i;
        expire_o  = force_i ||
                    (!restart_o && run_q && unit_tick_i && (cnt_q == val_t'(1)));
    end

    // Counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (force_i) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (restart_o) begin
            cnt_q <= next_val;
            run_q <= (next_val != '0);
        end else if (run_q && unit_tick_i) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == val_t'(1)) run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_pulse.sv
// Pulse stretcher: a start strobe drives the output high for LEN cycles,
// beginning the cycle after the strobe. A new start restarts the length.
module wdog_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic out_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] rem_q;

    // Remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          rem_q <= '0;
        else if (start_i)    rem_q <= CW'(LEN);
        else if (rem_q != 0) rem_q <= rem_q - 1'b1;
    end

    assign out_o = (rem_q != '0);
endmodule

// File: rtl/wdog_timer.sv
// Watchdog top: register file, prescaler, down-counter and one pulse
// stretcher per reset output. The time base comes from outside.
// Activity inputs are single-cycle pulses in the clk domain.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter logic [7:0] ADDR_BASE = 8'h10,
    parameter int         PULSE_LEN = 16,
    parameter int         MIN_DIV   = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sec_tick,
    input  logic       evt_ir,
    input  logic       evt_mouse,
    input  logic       evt_kbd,
    input  logic       evt_game_rd,
    output logic       kbc_rst,
    output logic       pwrgd_drop,
    output logic [3:0] irq_line_sel,
    output logic       expired
);
    logic [N_EVT-1:0] evt_en_w, evt_in_w;
    logic             unit_sec_w;
    logic [N_RST-1:0] route_w, rst_out_w;
    val_t             tv_w, load_val_w;
    logic             load_w, force_w, zero_w;
    logic             restart_w, expire_w, unit_tick_w, reload_w;

    wdog_regs #(.ADDR_BASE(ADDR_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .expire_i(expire_w),
        .evt_en_o(evt_en_w), .unit_sec_o(unit_sec_w), .route_o(route_w),
        .irq_sel_o(irq_line_sel), .tv_o(tv_w), .load_o(load_w),
        .load_val_o(load_val_w), .force_o(force_w), .zero_o(zero_w)
    );

    // Gather activity inputs in control-bit order and apply enables.
    always_comb begin
        evt_in_w[C_EN_IR]    = evt_ir;
        evt_in_w[C_EN_MOUSE] = evt_mouse;
        evt_in_w[C_EN_KBD]   = evt_kbd;
        evt_in_w[C_EN_GAME]  = evt_game_rd;
        reload_w             = |(evt_in_w & evt_en_w);
    end

    wdog_prescale #(.DIV(MIN_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear_i(restart_w), .tick_i(sec_tick),
        .bypass_i(unit_sec_w), .unit_tick_o(unit_tick_w)
    );

    wdog_count u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .load_val_i(load_val_w),
        .reload_i(reload_w), .tv_i(tv_w), .force_i(force_w),
        .unit_tick_i(unit_tick_w), .restart_o(restart_w), .expire_o(expire_w)
    );

    // One stretcher per routed reset output.
    for (genvar i = 0; i < N_RST; i++) begin : g_rst
        wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
            .clk(clk), .rst_n(rst_n), .start_i(expire_w && route_w[i]),
            .out_o(rst_out_w[i])
        );
    end

    assign kbc_rst    = rst_out_w[RST_KBC];
    assign pwrgd_drop = rst_out_w[RST_PWR];
    assign expired    = zero_w;
endmodule

// File: rtl/wdog_timer_chk.sv
// Checker: cycle-level properties of the watchdog, bound to the top.
module wdog_timer_chk #(
    parameter int PULSE_LEN = 16
) (
    input logic clk,
    input logic rst_n,
    input logic force_wr,
    input logic expire,
    input logic kbc_rst,
    input logic pwrgd_drop,
    input logic expired
);
    localparam int RW = $clog2(PULSE_LEN + 1) + 1;

    logic [RW-1:0] kbc_run, pwr_run;

    // Count high cycles of each output since the last expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || expire) begin
            kbc_run <= '0;
            pwr_run <= '0;
        end else begin
            if (kbc_rst)    kbc_run <= kbc_run + 1'b1;
            if (pwrgd_drop) pwr_run <= pwr_run + 1'b1;
        end
    end

    assert_kbc_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kbc_rst |-> (kbc_run < RW'(PULSE_LEN)));
    assert_pwr_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwrgd_drop |-> (pwr_run < RW'(PULSE_LEN)));
    assert_kbc_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kbc_rst) |-> expired);
    assert_pwr_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwrgd_drop) |-> expired);
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> expired);
    assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |-> expire);
endmodule

bind wdog_timer wdog_timer_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .force_wr(force_w), .expire(expire_w),
    .kbc_rst(kbc_rst), .pwrgd_drop(pwrgd_drop), .expired(expired)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] BASE = 8'h10;
    localparam logic [7:0] A_CTRL = BASE, A_CFG = BASE + 8'd1,
                           A_LO = BASE + 8'd2, A_HI = BASE + 8'd3;
    localparam int PLEN = 16;

    // {address, write data, expected read-back}
    localparam logic [23:0] VEC [8] = '{
        {8'h10, 8'h0F, 8'h0F},
        {8'h10, 8'hC5, 8'h05},
        {8'h11, 8'hFF, 8'hF7},
        {8'h11, 8'h00, 8'h00},
        {8'h12, 8'hA5, 8'hA5},
        {8'h13, 8'h5A, 8'h5A},
        {8'h12, 8'h00, 8'h00},
        {8'h13, 8'h00, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, sec_tick = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic evt_ir = 1'b0, evt_mouse = 1'b0, evt_kbd = 1'b0, evt_game_rd = 1'b0;
    logic kbc_rst, pwrgd_drop, expired;
    logic [3:0] irq_line_sel;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdog_timer #(.ADDR_BASE(BASE), .PULSE_LEN(PLEN)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .evt_ir(evt_ir), .evt_mouse(evt_mouse), .evt_kbd(evt_kbd),
        .evt_game_rd(evt_game_rd), .kbc_rst(kbc_rst), .pwrgd_drop(pwrgd_drop),
        .irq_line_sel(irq_line_sel), .expired(expired)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic evt(input int k);
        @(negedge clk);
        case (k)
            0: evt_ir = 1'b1;
            1: evt_mouse = 1'b1;
            2: evt_kbd = 1'b1;
            default: evt_game_rd = 1'b1;
        endcase
        @(negedge clk);
        {evt_ir, evt_mouse, evt_kbd, evt_game_rd} = '0;
    endtask

    // Count high samples of both outputs over 40 cycles, starting now.
    task automatic measure(output int nk, output int np);
        nk = 0; np = 0;
        for (int i = 0; i < 40; i++) begin
            if (kbc_rst) nk++;
            if (pwrgd_drop) np++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int nk, np;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and idle behaviour
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_CFG, d);  chk("R1 cfg", d, 0);
        rd(A_LO, d);   chk("R1 lo", d, 0);
        rd(A_HI, d);   chk("R1 hi", d, 0);
        chk("R1 outputs", {kbc_rst, pwrgd_drop, expired}, 0);
        ticks(3);
        chk("R1 idle", {kbc_rst, pwrgd_drop, expired}, 0);

        // R2: register map walked from the vector table
        for (int v = 0; v < 8; v++) begin
            wr(VEC[v][23:16], VEC[v][15:8]);
            rd(VEC[v][23:16], d);
            chk($sformatf("R2 row %0d", v), d, VEC[v][7:0]);
            if (v == 2) chk("R2 irq_sel", irq_line_sel, 4'hF);
        end

        // R4/R8: seconds units, keyboard-controller route only
        wr(A_CFG, 8'h03); wr(A_HI, 8'h00); wr(A_LO, 8'h03);
        ticks(2);
        chk("R4 early", {kbc_rst, expired}, 0);
        ticks(1);
        chk("R4 expiry", {kbc_rst, expired}, 2'b11);
        measure(nk, np);
        chk("R8 kbc length", nk, PLEN);
        chk("R8 unrouted pwr", np, 0);

        // R7: stopped after expiry
        ticks(5);
        measure(nk, np);
        chk("R7 no re-expiry", nk, 0);
        chk("R7 flag held", expired, 1);

        // R10: write-0 keeps the flag, write-1 clears it
        wr(A_CTRL, 8'h00); rd(A_CTRL, d); chk("R10 keep", d, 8'h20);
        wr(A_CTRL, 8'h20); rd(A_CTRL, d); chk("R10 clear", d, 8'h00);

        // R5: minutes units with a prescaler clear on reload
        wr(A_CFG, 8'h04); wr(A_LO, 8'h01);
        ticks(30);
        wr(A_LO, 8'h01);
        ticks(59);
        chk("R5 not before 60", {pwrgd_drop, expired}, 0);
        ticks(1);
        chk("R5 expiry", {pwrgd_drop, expired}, 2'b11);
        measure(nk, np);
        chk("R8 pwr length", np, PLEN);
        chk("R8 unrouted kbc", nk, 0);

        // R6: enabled keyboard reloads, disabled mouse ignored
        wr(A_CTRL, 8'h24); wr(A_CFG, 8'h01); wr(A_LO, 8'h02);
        ticks(1); evt(2); ticks(1);
        chk("R6 kbd reload", expired, 0);
        evt(1); ticks(1);
        chk("R6 mouse ignored", expired, 1);
        chk("R8 no route", {kbc_rst, pwrgd_drop}, 0);
        wr(A_CTRL, 8'h21);
        evt(0); ticks(1);
        chk("R6 ir restart", expired, 0);
        ticks(1);
        chk("R6 ir expiry", expired, 1);

        // R3: full 16-bit value, then zero value stops
        wr(A_CTRL, 8'h20); wr(A_HI, 8'h01); wr(A_LO, 8'h00);
        ticks(255);
        chk("R3 16-bit early", expired, 0);
        ticks(1);
        chk("R3 16-bit expiry", expired, 1);
        wr(A_CTRL, 8'h20); wr(A_LO, 8'h00); wr(A_HI, 8'h00);
        ticks(5);
        chk("R3 zero stops", expired, 0);

        // R11: reload coinciding with final tick wins
        wr(A_LO, 8'h01);
        @(negedge clk);
        sec_tick = 1'b1; reg_wr = 1'b1; reg_addr = A_LO; reg_wdata = 8'h01;
        @(negedge clk);
        sec_tick = 1'b0; reg_wr = 1'b0;
        chk("R11 reload wins", expired, 0);
        ticks(1);
        chk("R11 then expiry", expired, 1);

        // R9: forced expiry on both routes
        wr(A_CTRL, 8'h20); wr(A_CFG, 8'h07);
        wr(A_CTRL, 8'h10);
        chk("R9 force", {kbc_rst, pwrgd_drop, expired}, 3'b111);
        rd(A_CTRL, d);
        chk("R2 force reads 0", d, 8'h20);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule